// File: doc/BRIEF.md
# Address-Filtering Serial Receiver

This block receives asynchronous serial characters on an oversampled line. Its intended use is a shared link where many nodes listen and each character carries an extra flag bit after the data. The flag marks an address character apart from an ordinary data character. A node that is not being addressed arms a wait mode. While that mode is armed, the receiver discards every character whose flag bit is 0. Discarded characters leave the data register, the status flags and the interrupt requests untouched. When a character with the flag set arrives, the receiver accepts it as usual, records the flag and disarms the wait mode itself. Software then inspects the address and either re-arms the mode or keeps receiving.

The receiver is a state machine with the states IDLE, START, DATA, MPB and STOP. It advances only on cycles where the 16x sampling enable `tick` is high.

Its transitions are:
- IDLE to START: the line is seen low while reception is enabled in asynchronous mode.
- START to IDLE (false start): the line is high again at the middle of the start bit.
- START to DATA: the line is still low at that mid-point.
- DATA to MPB: after the last data bit, when the flag format is selected.
- DATA to STOP: after the last data bit, when the flag format is not selected.
- MPB to STOP: after the flag bit.
- STOP to IDLE: the stop bit is sampled and the character is handed to the status logic.
- Any state to IDLE (abort): `rx_en` is 0.

Top module: `mpr_rx`

## Requirements
- R1: A character is started only when `rx_en`=1 and `sync_mode`=0 and a low level on `rx` is seen. The low level must still be present at the middle of the start bit, 8 ticks after detection; otherwise the receiver returns to IDLE and nothing changes.
- R2: The character is laid out as follows, one bit per 16 ticks, each bit sampled at its middle:
  - a start bit of 0;
  - 8 data bits, least significant first;
  - when `mp_fmt`=1, one flag bit;
  - a stop bit.

  An accepted character with `rx_full`=0 is written to `rx_data` and sets `rx_full`.
- R3: With `rx_en`=0, no character is received and a character in progress is abandoned. `rx_full`, `rx_fer` and `rx_ovr` keep their values.
- R4: The wait flag `mpie` acts only when `mp_fmt`=1 and `sync_mode`=0. With `mp_fmt`=0, characters are accepted normally and `mpie` is left as written.
- R5: While the wait mode is in effect, a character whose flag bit is 0 has no effect. It does not change `rx_data`, it does not set `rx_full`, `rx_fer` or `rx_ovr`, and it raises no interrupt request.
- R6: While the wait mode is in effect, a character whose flag bit is 1 sets `rx_mpb`, clears `mpie` and is accepted like a normal character.
- R7: In flag format, every accepted character copies its flag bit into `rx_mpb`.
- R8: A character accepted while `rx_full`=1 sets `rx_ovr` and leaves `rx_data` unchanged.
- R9: An accepted character whose stop bit is sampled as 0 sets `rx_fer`; its data is still transferred under R2.
- R10: `rx_full`, `rx_fer` and `rx_ovr` are cleared only by their own strobes `clr_full`, `clr_fer` and `clr_ovr`, never by a new character. A setting event wins over a clear in the same cycle.
- R11: `rx_irq` equals `rx_full` AND `rie`. `err_irq` equals (`rx_fer` OR `rx_ovr`) AND `eie`.
- R12: A pulse on `mpie_wr` loads `mpie` from `mpie_wd`. A hardware clear under R6 in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sampling enable at 16x the bit rate |
| rx | input | 1 | Serial receive line, idle high |
| rx_en | input | 1 | Receive enable |
| sync_mode | input | 1 | 1 selects synchronous mode (no asynchronous reception) |
| mp_fmt | input | 1 | 1 selects the format with a flag bit |
| mpie_wr | input | 1 | Write strobe for the wait flag |
| mpie_wd | input | 1 | Value written to the wait flag |
| rie | input | 1 | Receive interrupt enable |
| eie | input | 1 | Error interrupt enable |
| clr_full | input | 1 | Clear strobe for `rx_full` |
| clr_fer | input | 1 | Clear strobe for `rx_fer` |
| clr_ovr | input | 1 | Clear strobe for `rx_ovr` |
| rx_data | output | DATA_W | Received data register |
| rx_full | output | 1 | Receive-full flag |
| rx_fer | output | 1 | Framing error flag |
| rx_ovr | output | 1 | Overrun flag |
| rx_mpb | output | 1 | Flag bit of the last accepted character |
| mpie | output | 1 | Wait flag (armed address filter) |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
Several properties are checked on every cycle:
- a disabled receiver always sits in IDLE;
- a completed character is reported as a single-cycle pulse;
- a character dropped in wait mode leaves the data register and flags unchanged;
- a waking character disarms the filter and records its flag;
- an overrun never overwrites the data register.

Other behaviours only the bench's scenarios can show:
- the bit order on the line, the mid-bit sampling point and false-start rejection;
- that flags survive a disable in the middle of a character;
- that the filter follows a whole sequence of armed, dropped, woken and normal characters mixed with random clears.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_MPB,
        ST_STOP
    } rx_state_t;
endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[i] <= 1'b1;
                else if (i == 0) pipe_q[i] <= din;
                else pipe_q[i] <= pipe_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/mpr_frame.sv
module mpr_frame
    import mpr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic              rx_en,
    input  logic              sync_mode,
    input  logic              mp_fmt,
    output logic              done,
    output logic              stop_ok,
    output logic              mp_bit,
    output logic [DATA_W-1:0] data
);
    localparam int CW = $clog2(OVS);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);
    localparam logic [BW-1:0] TOPB = BW'(DATA_W - 1);

    rx_state_t         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              mp_q, done_q, stop_q;

    wire at_mid = tick && (cnt_q == MID);
    wire at_end = tick && (cnt_q == LAST);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rx_en && !sync_mode && tick && !rx) state_d = ST_START;
            ST_START: if (!rx_en) state_d = ST_IDLE;
                      else if (at_mid) state_d = rx ? ST_IDLE : ST_DATA;
            ST_DATA:  if (!rx_en) state_d = ST_IDLE;
                      else if (at_end && bit_q == TOPB) state_d = mp_fmt ? ST_MPB : ST_STOP;
            ST_MPB:   if (!rx_en) state_d = ST_IDLE;
                      else if (at_end) state_d = ST_STOP;
            ST_STOP:  if (!rx_en || at_end) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            mp_q    <= 1'b0;
            done_q  <= 1'b0;
            stop_q  <= 1'b1;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_IDLE || (state_q == ST_START && at_mid)) begin
                cnt_q <= '0;
                bit_q <= '0;
            end else if (tick) begin
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
            if (state_q == ST_DATA && at_end) begin
                shift_q <= {rx, shift_q[DATA_W-1:1]};
                bit_q   <= bit_q + 1'b1;
                mp_q    <= 1'b0;
            end
            if (state_q == ST_MPB && at_end) mp_q <= rx;
            if (state_q == ST_STOP && at_end && rx_en) begin
                done_q <= 1'b1;
                stop_q <= rx;
            end
        end
    end

    assign done    = done_q;
    assign stop_ok = stop_q;
    assign mp_bit  = mp_q;
    assign data    = shift_q;

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> state_q == ST_IDLE); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R2
    AST_NO_START_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && sync_mode) |=> state_q == ST_IDLE); // R1
endmodule

// File: rtl/mpr_status.sv
module mpr_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              stop_ok,
    input  logic              mp_bit,
    input  logic [DATA_W-1:0] data,
    input  logic              sync_mode,
    input  logic              mp_fmt,
    input  logic              mpie_wr,
    input  logic              mpie_wd,
    input  logic              clr_full,
    input  logic              clr_fer,
    input  logic              clr_ovr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_fer,
    output logic              rx_ovr,
    output logic              rx_mpb,
    output logic              mpie
);
    logic [DATA_W-1:0] data_q;
    logic full_q, fer_q, ovr_q, mpb_q, mpie_q;

    wire wait_on = mpie_q && mp_fmt && !sync_mode;
    wire drop    = done && wait_on && !mp_bit;
    wire wake    = done && wait_on && mp_bit;
    wire accept  = done && !drop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
            fer_q  <= 1'b0;
            ovr_q  <= 1'b0;
            mpb_q  <= 1'b0;
            mpie_q <= 1'b0;
        end else begin
            if (accept && !full_q) begin
                data_q <= data;
                full_q <= 1'b1;
            end else if (clr_full) begin
                full_q <= 1'b0;
            end
            if (accept && full_q) ovr_q <= 1'b1;
            else if (clr_ovr)     ovr_q <= 1'b0;
            if (accept && !stop_ok) fer_q <= 1'b1;
            else if (clr_fer)       fer_q <= 1'b0;
            if (accept && mp_fmt) mpb_q <= mp_bit;
            if (wake)         mpie_q <= 1'b0;
            else if (mpie_wr) mpie_q <= mpie_wd;
        end
    end

    assign rx_data = data_q;
    assign rx_full = full_q;
    assign rx_fer  = fer_q;
    assign rx_ovr  = ovr_q;
    assign rx_mpb  = mpb_q;
    assign mpie    = mpie_q;

    AST_DROP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> $stable(data_q) && (full_q <= $past(full_q)) &&
                 (fer_q <= $past(fer_q)) && (ovr_q <= $past(ovr_q))); // R5
    AST_WAKE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !mpie_q && mpb_q); // R6
    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && full_q) |=> $stable(data_q) && ovr_q); // R8
endmodule

// File: rtl/mpr_rx.sv
module mpr_rx #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic              rx_en,
    input  logic              sync_mode,
    input  logic              mp_fmt,
    input  logic              mpie_wr,
    input  logic              mpie_wd,
    input  logic              rie,
    input  logic              eie,
    input  logic              clr_full,
    input  logic              clr_fer,
    input  logic              clr_ovr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_fer,
    output logic              rx_ovr,
    output logic              rx_mpb,
    output logic              mpie,
    output logic              rx_irq,
    output logic              err_irq
);
    logic              rx_s, f_done, f_stop, f_mp;
    logic [DATA_W-1:0] f_data;

    mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx), .dout(rx_s)
    );

    mpr_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s), .rx_en(rx_en),
        .sync_mode(sync_mode), .mp_fmt(mp_fmt), .done(f_done),
        .stop_ok(f_stop), .mp_bit(f_mp), .data(f_data)
    );

    mpr_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .done(f_done), .stop_ok(f_stop),
        .mp_bit(f_mp), .data(f_data), .sync_mode(sync_mode), .mp_fmt(mp_fmt),
        .mpie_wr(mpie_wr), .mpie_wd(mpie_wd), .clr_full(clr_full),
        .clr_fer(clr_fer), .clr_ovr(clr_ovr), .rx_data(rx_data),
        .rx_full(rx_full), .rx_fer(rx_fer), .rx_ovr(rx_ovr),
        .rx_mpb(rx_mpb), .mpie(mpie)
    );

    assign rx_irq  = rx_full && rie;
    assign err_irq = (rx_fer || rx_ovr) && eie;

    AST_ERR_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_irq) |-> eie && (rx_fer || rx_ovr)); // R11
endmodule

// File: tb/sim_mpr_rx.sv
module sim_mpr_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1, rx = 1'b1, rx_en = 1'b0, sync_mode = 1'b0, mp_fmt = 1'b0;
    logic mpie_wr = 1'b0, mpie_wd = 1'b0, rie = 1'b0, eie = 1'b0;
    logic clr_full = 1'b0, clr_fer = 1'b0, clr_ovr = 1'b0;
    logic [7:0] rx_data;
    logic rx_full, rx_fer, rx_ovr, rx_mpb, mpie, rx_irq, err_irq;

    int checks = 0, errors = 0;
    logic [7:0] m_data = 8'h00;
    logic m_full = 0, m_fer = 0, m_ovr = 0, m_mpb = 0, m_mpie = 0;

    always #5 clk = ~clk;

    mpr_rx u0 (.*);

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "rx_data", rx_data, m_data);
        chk(tag, "rx_full", rx_full, m_full);
        chk(tag, "rx_fer", rx_fer, m_fer);
        chk(tag, "rx_ovr", rx_ovr, m_ovr);
        chk(tag, "rx_mpb", rx_mpb, m_mpb);
        chk(tag, "mpie", mpie, m_mpie);
        chk(tag, "rx_irq", rx_irq, m_full & rie);
        chk(tag, "err_irq", err_irq, (m_fer | m_ovr) & eie);
    endtask

    // expected effect of one complete character, from R1..R9
    task automatic model_frame(input logic [7:0] d, input logic mb, input logic stp);
        logic wait_on;
        if (!rx_en || sync_mode) return;
        wait_on = m_mpie && mp_fmt && !sync_mode;
        if (wait_on && !mb) return;
        if (wait_on) m_mpie = 1'b0;
        if (m_full) m_ovr = 1'b1;
        else begin m_data = d; m_full = 1'b1; end
        if (!stp) m_fer = 1'b1;
        if (mp_fmt) m_mpb = mb;
    endtask

    task automatic send_bit(input logic b);
        rx = b;
        repeat (16) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic mb, input logic stp);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        if (mp_fmt) send_bit(mb);
        send_bit(stp);
        rx = 1'b1;
        repeat (24) @(negedge clk);
        model_frame(d, mb, stp);
    endtask

    task automatic pulse_clr(input logic f, input logic e, input logic o);
        clr_full = f; clr_fer = e; clr_ovr = o;
        @(negedge clk);
        clr_full = 0; clr_fer = 0; clr_ovr = 0;
        if (f) m_full = 0;
        if (e) m_fer = 0;
        if (o) m_ovr = 0;
    endtask

    task automatic write_mpie(input logic v);
        mpie_wr = 1'b1; mpie_wd = v;
        @(negedge clk);
        mpie_wr = 1'b0;
        m_mpie = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R2 reset");

        rx_en = 1'b1; rie = 1'b1; eie = 1'b1;
        send_frame(8'hA5, 1'b0, 1'b1);
        check_all("R2 basic");
        send_frame(8'h3C, 1'b0, 1'b1);
        check_all("R8 overrun");
        pulse_clr(0, 0, 1);
        check_all("R10 clear ovr only");
        pulse_clr(1, 0, 0);
        check_all("R10 clear full");
        send_frame(8'h81, 1'b0, 1'b0);
        check_all("R9 framing");
        pulse_clr(1, 1, 0);

        // R1: short low pulse is a false start
        rx = 1'b0; repeat (3) @(negedge clk); rx = 1'b1;
        repeat (40) @(negedge clk);
        check_all("R1 false start");
        send_frame(8'h5A, 1'b0, 1'b1);
        check_all("R1 after false start");

        // R3: disable mid-character, flags retained
        send_frame(8'h11, 1'b0, 1'b0);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        rx_en = 1'b0;
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        rx = 1'b1; repeat (24) @(negedge clk);
        check_all("R3 abandon keeps flags");
        send_frame(8'h77, 1'b0, 1'b1);
        check_all("R1 disabled ignores line");
        rx_en = 1'b1;
        sync_mode = 1'b1;
        send_frame(8'h66, 1'b0, 1'b1);
        check_all("R1 sync mode ignores line");
        sync_mode = 1'b0;
        pulse_clr(1, 1, 1);

        // address filter sequence
        mp_fmt = 1'b1;
        write_mpie(1'b1);
        check_all("R12 write mpie");
        send_frame(8'h42, 1'b0, 1'b0);
        check_all("R5 dropped while waiting");
        send_frame(8'h09, 1'b1, 1'b1);
        check_all("R6 wake");
        pulse_clr(1, 0, 0);
        send_frame(8'hC3, 1'b0, 1'b1);
        check_all("R7 flag follows frame");
        pulse_clr(1, 0, 0);
        mp_fmt = 1'b0;
        write_mpie(1'b1);
        send_frame(8'hE7, 1'b0, 1'b1);
        check_all("R4 filter off without flag format");
        rie = 1'b0; eie = 1'b0;
        @(negedge clk);
        check_all("R11 irq gated");
        pulse_clr(1, 1, 1);
        write_mpie(1'b0);

        // constrained random
        for (int n = 0; n < 40; n++) begin
            logic [7:0] d;
            mp_fmt = 1'($urandom % 2);
            rie = 1'($urandom % 2);
            eie = 1'($urandom % 2);
            if ($urandom % 3 == 0) write_mpie(1'($urandom % 2));
            if ($urandom % 2 == 0)
                pulse_clr(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
            d = 8'($urandom);
            send_frame(d, 1'($urandom % 2), ($urandom % 6) != 0);
            check_all("R2 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule